// File: doc/BRIEF.md
# I2C Slave Buffer Flow Control

This block sits on the target side of an I2C controller. It connects the byte engine, which handles the bus, to a small slave data buffer that the host fills and drains. When the controller is addressed as a target, the block accepts or refuses the address according to the enable bits. It then serves each byte the engine asks for. During a master write, received bytes go into the buffer. During a master read, bytes are taken from the buffer and sent.

The buffer may be full when a byte arrives, or empty when a byte is wanted. This is checked on every byte, whether it is the first byte of the transfer or a later one. One policy bit decides what happens then. In hold mode, SCL is held low until the host frees space or supplies data, so no byte is lost. In refuse mode, the bus is released at once: a received byte is answered with not-acknowledge, and a transmit byte is sent as 0xFF with an underrun flag set.

The block also has a self-clearing flush of the buffer. It raises an interrupt request on its events, gated by a global enable and a per-event mask.

Top module: `i2c_slave_flow`

## Requirements
- R1: After reset the buffer is empty, and addr_ack, rx_done, tx_done, scl_hold, underrun, flush_busy and irq are all 0.
- R2: While cfg_slave_en is 0, no address or general call is acknowledged and byte requests get no rx_done or tx_done.
- R3: A general call (gcall_hit) is acknowledged only when cfg_slave_en and cfg_gcall_en are both 1, and it always starts a receive transfer.
- R4: An accepted address_hit gives addr_ack one cycle later. bus_read=1 starts a transmit transfer and bus_read=0 starts a receive transfer.
- R5: In a receive transfer with space in the buffer, rx_done and rx_ack=1 appear one cycle after rx_req, and the byte is stored. The buffer holds 4 bytes and hands them back oldest first.
- R6: In refuse mode (cfg_hold_mode=0), a byte that arrives while the buffer is full gets rx_done with rx_ack=0, and the buffer contents are unchanged.
- R7: In hold mode (cfg_hold_mode=1), a byte that arrives while the buffer is full raises scl_hold one cycle later. The hold stays until space appears. By the second clock edge after the host pop, scl_hold is 0 and the byte is stored and acknowledged.
- R8: In a transmit transfer with data in the buffer, tx_done appears one cycle after tx_req, with tx_data equal to the oldest byte.
- R9: In refuse mode, a transmit request while the buffer is empty gets tx_done with tx_data=0xFF and sets underrun. underrun stays set until the next accepted address.
- R10: In hold mode, a transmit request while the buffer is empty holds scl_hold. By the second clock edge after a host write, the hold is released and the new byte is delivered.
- R11: A flush_req pulse sets flush_busy on the next cycle. Within two further cycles the buffer is empty and flush_busy is 0.
- R12: irq pulses for one cycle, in the same cycle as the event's output, only when cfg_irq_en is 1 and the event's mask bit is set. The mask bits are: bit0 address accepted, bit1 receive refused, bit2 transmit underrun, bit3 SCL hold started.
- R13: xfer_end ends the transfer and releases any SCL hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_slave_en | input | 1 | Enable target responses |
| cfg_gcall_en | input | 1 | Enable general-call response |
| cfg_hold_mode | input | 1 | 1 = hold SCL low when not ready, 0 = refuse |
| cfg_irq_en | input | 1 | Global interrupt enable |
| cfg_irq_mask | input | 4 | Per-event interrupt mask |
| flush_req | input | 1 | Pulse that requests a buffer flush |
| flush_busy | output | 1 | Flush in progress, clears itself |
| host_wr_en | input | 1 | Host writes a byte into the buffer |
| host_wr_data | input | 8 | Host write data |
| host_rd_en | input | 1 | Host removes the oldest byte |
| host_rd_data | output | 8 | Oldest byte in the buffer |
| buf_full | output | 1 | Buffer full |
| buf_empty | output | 1 | Buffer empty |
| addr_hit | input | 1 | Pulse: own address seen on the bus |
| gcall_hit | input | 1 | Pulse: general call seen on the bus |
| bus_read | input | 1 | Direction bit of the address (1 = master read) |
| xfer_end | input | 1 | Pulse: stop or end of transfer |
| addr_ack | output | 1 | Pulse: acknowledge the address |
| rx_req | input | 1 | Engine holds a received byte for decision |
| rx_data | input | 8 | Received byte |
| rx_done | output | 1 | Pulse: receive byte handled |
| rx_ack | output | 1 | Acknowledge (1) or not-acknowledge (0), valid with rx_done |
| tx_req | input | 1 | Engine needs a byte to send |
| tx_done | output | 1 | Pulse: transmit byte ready |
| tx_data | output | 8 | Byte to send, valid with tx_done |
| scl_hold | output | 1 | Hold SCL low |
| underrun | output | 1 | Transmit underrun flag |
| irq | output | 1 | Interrupt request pulse |

## Verification
The transfer state can be wrong, for example stuck in receive after an end of transfer or left active after the enable drops. This shows on the next byte request: rx_done or tx_done appears when it should not, one cycle after the request. A wrong fill count in the buffer shows one cycle after the byte that crosses the limit. In hold mode it shows as scl_hold rising early, or never. In refuse mode it shows as rx_ack at 0 or tx_data at 0xFF. A wrong hold register shows as scl_hold still high two edges after the buffer became ready.

// File: rtl/i2csf_pkg.sv
package i2csf_pkg;
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RX   = 2'd1,
        XS_TX   = 2'd2
    } xstate_e;

    localparam int NUM_EV   = 4;
    localparam int EV_ADDR  = 0;
    localparam int EV_NACK  = 1;
    localparam int EV_UNDER = 2;
    localparam int EV_HOLD  = 3;
endpackage

// File: rtl/i2csf_fifo.sv
module i2csf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_s;

    fifo_s st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rp];

    always_comb begin
        logic do_push;
        logic do_pop;
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_pop) begin
                st_d.rp = bump(st_q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/i2csf_xfer.sv
module i2csf_xfer
    import i2csf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_slave_en,
    input  logic              cfg_gcall_en,
    input  logic              cfg_hold_mode,
    input  logic              addr_hit,
    input  logic              gcall_hit,
    input  logic              bus_read,
    input  logic              xfer_end,
    input  logic              rx_req,
    input  logic [W-1:0]      rx_data,
    input  logic              tx_req,
    input  logic              buf_full,
    input  logic              buf_empty,
    input  logic [W-1:0]      buf_head,
    input  logic              flush_active,
    output logic              buf_push,
    output logic [W-1:0]      buf_push_data,
    output logic              buf_pop,
    output logic              addr_ack,
    output logic              rx_done,
    output logic              rx_ack,
    output logic              tx_done,
    output logic [W-1:0]      tx_data,
    output logic              scl_hold,
    output logic              underrun,
    output logic [NUM_EV-1:0] ev
);
    localparam logic [W-1:0] FILL_BYTE = {W{1'b1}};

    typedef struct packed {
        xstate_e      state;
        logic         addr_ack;
        logic         rx_done;
        logic         rx_ack;
        logic         tx_done;
        logic [W-1:0] tx_data;
        logic         hold;
        logic         underrun;
    } xfer_s;

    xfer_s st_d, st_q;

    always_comb begin
        logic accept;
        st_d          = st_q;
        st_d.addr_ack = 1'b0;
        st_d.rx_done  = 1'b0;
        st_d.rx_ack   = 1'b0;
        st_d.tx_done  = 1'b0;
        st_d.hold     = 1'b0;
        buf_push      = 1'b0;
        buf_push_data = rx_data;
        buf_pop       = 1'b0;
        ev            = '0;
        accept        = cfg_slave_en && (addr_hit || (gcall_hit && cfg_gcall_en));

        if (!cfg_slave_en || xfer_end) begin
            st_d.state = XS_IDLE;
        end else if (accept) begin
            st_d.addr_ack  = 1'b1;
            st_d.state     = (addr_hit && bus_read) ? XS_TX : XS_RX;
            st_d.underrun  = 1'b0;
            ev[EV_ADDR]    = 1'b1;
        end else begin
            case (st_q.state)
                XS_RX: begin
                    if (rx_req && !st_q.rx_done && !flush_active) begin
                        if (!buf_full) begin
                            buf_push     = 1'b1;
                            st_d.rx_done = 1'b1;
                            st_d.rx_ack  = 1'b1;
                        end else if (cfg_hold_mode) begin
                            st_d.hold = 1'b1;
                        end else begin
                            st_d.rx_done = 1'b1;
                            st_d.rx_ack  = 1'b0;
                            ev[EV_NACK]  = 1'b1;
                        end
                    end
                end
                XS_TX: begin
                    if (tx_req && !st_q.tx_done && !flush_active) begin
                        if (!buf_empty) begin
                            buf_pop      = 1'b1;
                            st_d.tx_done = 1'b1;
                            st_d.tx_data = buf_head;
                        end else if (cfg_hold_mode) begin
                            st_d.hold = 1'b1;
                        end else begin
                            st_d.tx_done  = 1'b1;
                            st_d.tx_data  = FILL_BYTE;
                            st_d.underrun = 1'b1;
                            ev[EV_UNDER]  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        ev[EV_HOLD] = st_d.hold && !st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= XS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_ack = st_q.addr_ack;
    assign rx_done  = st_q.rx_done;
    assign rx_ack   = st_q.rx_ack;
    assign tx_done  = st_q.tx_done;
    assign tx_data  = st_q.tx_data;
    assign scl_hold = st_q.hold;
    assign underrun = st_q.underrun;
endmodule

// File: rtl/i2csf_evctl.sv
module i2csf_evctl
    import i2csf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              buf_empty,
    input  logic [NUM_EV-1:0] ev,
    input  logic              cfg_irq_en,
    input  logic [NUM_EV-1:0] cfg_irq_mask,
    output logic              flush_active,
    output logic              irq
);
    typedef struct packed {
        logic flush;
        logic irq;
    } ctl_s;

    ctl_s st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flush = flush_req || (st_q.flush && !buf_empty);
        st_d.irq   = cfg_irq_en && |(ev & cfg_irq_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flush_active = st_q.flush;
    assign irq          = st_q.irq;
endmodule

// File: rtl/i2c_slave_flow.sv
module i2c_slave_flow
    import i2csf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_slave_en,
    input  logic              cfg_gcall_en,
    input  logic              cfg_hold_mode,
    input  logic              cfg_irq_en,
    input  logic [NUM_EV-1:0] cfg_irq_mask,
    input  logic              flush_req,
    output logic              flush_busy,
    input  logic              host_wr_en,
    input  logic [DW-1:0]     host_wr_data,
    input  logic              host_rd_en,
    output logic [DW-1:0]     host_rd_data,
    output logic              buf_full,
    output logic              buf_empty,
    input  logic              addr_hit,
    input  logic              gcall_hit,
    input  logic              bus_read,
    input  logic              xfer_end,
    output logic              addr_ack,
    input  logic              rx_req,
    input  logic [DW-1:0]     rx_data,
    output logic              rx_done,
    output logic              rx_ack,
    input  logic              tx_req,
    output logic              tx_done,
    output logic [DW-1:0]     tx_data,
    output logic              scl_hold,
    output logic              underrun,
    output logic              irq
);
    logic              bus_push;
    logic [DW-1:0]     bus_push_data;
    logic              bus_pop;
    logic              flush_active;
    logic [NUM_EV-1:0] ev;
    logic              f_push;
    logic [DW-1:0]     f_din;
    logic              f_pop;

    // bus side takes the buffer port when both sides act in one cycle
    assign f_push = bus_push || host_wr_en;
    assign f_din  = bus_push ? bus_push_data : host_wr_data;
    assign f_pop  = bus_pop || host_rd_en;

    i2csf_fifo #(.W(DW), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush_active),
        .push  (f_push),
        .din   (f_din),
        .pop   (f_pop),
        .head  (host_rd_data),
        .full  (buf_full),
        .empty (buf_empty)
    );

    i2csf_xfer #(.W(DW)) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_slave_en  (cfg_slave_en),
        .cfg_gcall_en  (cfg_gcall_en),
        .cfg_hold_mode (cfg_hold_mode),
        .addr_hit      (addr_hit),
        .gcall_hit     (gcall_hit),
        .bus_read      (bus_read),
        .xfer_end      (xfer_end),
        .rx_req        (rx_req),
        .rx_data       (rx_data),
        .tx_req        (tx_req),
        .buf_full      (buf_full),
        .buf_empty     (buf_empty),
        .buf_head      (host_rd_data),
        .flush_active  (flush_active),
        .buf_push      (bus_push),
        .buf_push_data (bus_push_data),
        .buf_pop       (bus_pop),
        .addr_ack      (addr_ack),
        .rx_done       (rx_done),
        .rx_ack        (rx_ack),
        .tx_done       (tx_done),
        .tx_data       (tx_data),
        .scl_hold      (scl_hold),
        .underrun      (underrun),
        .ev            (ev)
    );

    i2csf_evctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_req    (flush_req),
        .buf_empty    (buf_empty),
        .ev           (ev),
        .cfg_irq_en   (cfg_irq_en),
        .cfg_irq_mask (cfg_irq_mask),
        .flush_active (flush_active),
        .irq          (irq)
    );

    assign flush_busy = flush_active;
endmodule

// File: rtl/i2csf_sva.sv
module i2csf_sva #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_slave_en,
    input logic          cfg_hold_mode,
    input logic          cfg_irq_en,
    input logic          buf_full,
    input logic          buf_empty,
    input logic          addr_ack,
    input logic          rx_done,
    input logic          rx_ack,
    input logic          tx_done,
    input logic [DW-1:0] tx_data,
    input logic          scl_hold,
    input logic          underrun,
    input logic          flush_busy,
    input logic          irq
);
    a_r2_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_slave_en |=> (!addr_ack && !rx_done && !tx_done));

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_full && buf_empty));

    a_r6_nack_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_ack) |-> $past(buf_full));

    a_r7_hold_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> $past(cfg_hold_mode));

    a_r9_underrun_sends_ff: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> (tx_done && tx_data == {DW{1'b1}}));

    a_r11_flush_ends_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_busy) |-> buf_empty);

    a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(cfg_irq_en));
endmodule

bind i2c_slave_flow i2csf_sva #(.DW(DW)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_slave_en  (cfg_slave_en),
    .cfg_hold_mode (cfg_hold_mode),
    .cfg_irq_en    (cfg_irq_en),
    .buf_full      (buf_full),
    .buf_empty     (buf_empty),
    .addr_ack      (addr_ack),
    .rx_done       (rx_done),
    .rx_ack        (rx_ack),
    .tx_done       (tx_done),
    .tx_data       (tx_data),
    .scl_hold      (scl_hold),
    .underrun      (underrun),
    .flush_busy    (flush_busy),
    .irq           (irq)
);

// File: tb/i2c_slave_flow_test.sv
module i2c_slave_flow_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_slave_en = 0, cfg_gcall_en = 0, cfg_hold_mode = 0, cfg_irq_en = 0;
    logic [3:0] cfg_irq_mask = '0;
    logic       flush_req = 0, host_wr_en = 0, host_rd_en = 0;
    logic [7:0] host_wr_data = '0, rx_data = '0;
    logic       addr_hit = 0, gcall_hit = 0, bus_read = 0, xfer_end = 0;
    logic       rx_req = 0, tx_req = 0;
    logic       flush_busy, buf_full, buf_empty, addr_ack, rx_done, rx_ack;
    logic       tx_done, scl_hold, underrun, irq;
    logic [7:0] host_rd_data, tx_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    i2c_slave_flow uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_slave_en(cfg_slave_en), .cfg_gcall_en(cfg_gcall_en),
        .cfg_hold_mode(cfg_hold_mode), .cfg_irq_en(cfg_irq_en),
        .cfg_irq_mask(cfg_irq_mask), .flush_req(flush_req), .flush_busy(flush_busy),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .buf_full(buf_full), .buf_empty(buf_empty),
        .addr_hit(addr_hit), .gcall_hit(gcall_hit), .bus_read(bus_read),
        .xfer_end(xfer_end), .addr_ack(addr_ack),
        .rx_req(rx_req), .rx_data(rx_data), .rx_done(rx_done), .rx_ack(rx_ack),
        .tx_req(tx_req), .tx_done(tx_done), .tx_data(tx_data),
        .scl_hold(scl_hold), .underrun(underrun), .irq(irq)
    );

    // {slave_en, gcall_en, addr_hit, gcall_hit, expected addr_ack}
    localparam logic [4:0] VEC [6] = '{
        5'b1_0_1_0_1,
        5'b0_0_1_0_0,
        5'b1_0_0_1_0,
        5'b1_1_0_1_1,
        5'b0_1_0_1_0,
        5'b1_1_1_0_1
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic end_xfer();
        xfer_end = 1; tick(); xfer_end = 0;
    endtask

    task automatic open_xfer(input logic rd);
        addr_hit = 1; bus_read = rd; tick(); addr_hit = 0;
        chk("R4 addr_ack", addr_ack, 1);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic exp_ack, input string tag);
        rx_req = 1; rx_data = d; tick();
        chk({tag, " rx_done"}, rx_done, 1);
        chk({tag, " rx_ack"}, rx_ack, exp_ack);
        rx_req = 0; tick();
    endtask

    task automatic host_pop(input logic [7:0] exp, input string tag);
        chk({tag, " host_rd_data"}, host_rd_data, exp);
        host_rd_en = 1; tick(); host_rd_en = 0;
    endtask

    task automatic host_push(input logic [7:0] d);
        host_wr_en = 1; host_wr_data = d; tick(); host_wr_en = 0;
    endtask

    task automatic get_tx(input logic [7:0] exp, input string tag);
        tx_req = 1; tick();
        chk({tag, " tx_done"}, tx_done, 1);
        chk({tag, " tx_data"}, tx_data, exp);
        tx_req = 0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 outputs", {addr_ack, rx_done, tx_done, scl_hold, underrun, flush_busy, irq}, 0);

        // R2/R3/R4 address gating table, irq disabled (R12)
        cfg_irq_mask = 4'b0001;
        for (int i = 0; i < 6; i++) begin
            cfg_slave_en = VEC[i][4];
            cfg_gcall_en = VEC[i][3];
            addr_hit     = VEC[i][2];
            gcall_hit    = VEC[i][1];
            bus_read     = 0;
            tick();
            addr_hit = 0; gcall_hit = 0;
            chk("R3 R4 R2 addr_ack table", addr_ack, VEC[i][0]);
            chk("R12 irq off", irq, 0);
            end_xfer();
        end

        // R2 disabled slave ignores byte requests
        cfg_slave_en = 0;
        addr_hit = 1; tick(); addr_hit = 0;
        chk("R2 no addr_ack", addr_ack, 0);
        rx_req = 1; rx_data = 8'h5A;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 no rx_done", rx_done, 0);
        end
        rx_req = 0;
        chk("R2 buffer untouched", buf_empty, 1);

        // R3 general call goes to receive
        cfg_slave_en = 1; cfg_gcall_en = 1;
        gcall_hit = 1; tick(); gcall_hit = 0;
        chk("R3 gcall ack", addr_ack, 1);
        send_rx(8'h07, 1, "R3 gcall receive");
        host_pop(8'h07, "R3");
        end_xfer();

        // R5 receive with space, R12 address event
        cfg_hold_mode = 0; cfg_irq_en = 1; cfg_irq_mask = 4'b0001;
        addr_hit = 1; bus_read = 0; tick(); addr_hit = 0;
        chk("R4 addr_ack write", addr_ack, 1);
        chk("R12 irq addr event", irq, 1);
        send_rx(8'h11, 1, "R5");
        send_rx(8'h22, 1, "R5");
        send_rx(8'h33, 1, "R5");
        send_rx(8'h44, 1, "R5");
        chk("R5 full after four", buf_full, 1);

        // R6 refuse while full
        rx_req = 1; rx_data = 8'h55; tick();
        chk("R6 rx_done", rx_done, 1);
        chk("R6 rx_ack nack", rx_ack, 0);
        chk("R12 masked nack no irq", irq, 0);
        rx_req = 0; tick();
        chk("R6 still full", buf_full, 1);
        host_pop(8'h11, "R6 R5 order");
        host_pop(8'h22, "R5 order");

        // R7 hold while full
        cfg_hold_mode = 1; cfg_irq_mask = 4'b1000;
        send_rx(8'h66, 1, "R7 fill");
        send_rx(8'h77, 1, "R7 fill");
        rx_req = 1; rx_data = 8'h88; tick();
        chk("R7 hold raised", scl_hold, 1);
        chk("R7 no done while held", rx_done, 0);
        chk("R12 hold event irq", irq, 1);
        tick();
        chk("R7 hold kept", scl_hold, 1);
        chk("R12 irq one pulse", irq, 0);
        host_rd_en = 1; tick(); host_rd_en = 0;
        tick();
        chk("R7 hold released", scl_hold, 0);
        chk("R7 done after space", rx_done, 1);
        chk("R7 ack after space", rx_ack, 1);
        rx_req = 0; tick();
        host_pop(8'h44, "R7 order");
        host_pop(8'h66, "R7 order");
        end_xfer();

        // R11 flush
        flush_req = 1; tick(); flush_req = 0;
        chk("R11 flush_busy set", flush_busy, 1);
        tick(); tick();
        chk("R11 flush_busy clear", flush_busy, 0);
        chk("R11 buffer empty", buf_empty, 1);

        // R9 underrun in refuse mode
        cfg_hold_mode = 0; cfg_irq_mask = 4'b0100;
        open_xfer(1);
        tx_req = 1; tick();
        chk("R9 tx_done", tx_done, 1);
        chk("R9 tx_data ff", tx_data, 8'hFF);
        chk("R9 underrun set", underrun, 1);
        chk("R12 underrun irq", irq, 1);
        tx_req = 0; tick();

        // R8 transmit oldest first
        host_push(8'hA1);
        host_push(8'hB2);
        get_tx(8'hA1, "R8");
        chk("R9 underrun sticky", underrun, 1);
        get_tx(8'hB2, "R8");
        end_xfer();
        open_xfer(1);
        chk("R9 underrun cleared", underrun, 0);

        // R10 hold while empty
        cfg_hold_mode = 1; cfg_irq_mask = 4'b1000;
        tx_req = 1; tick();
        chk("R10 hold raised", scl_hold, 1);
        chk("R10 no tx_done", tx_done, 0);
        chk("R12 hold irq", irq, 1);
        tick();
        host_push(8'hC3);
        tick();
        chk("R10 hold released", scl_hold, 0);
        chk("R10 tx_done", tx_done, 1);
        chk("R10 tx_data", tx_data, 8'hC3);
        tx_req = 0; tick();

        // R13 end of transfer drops the hold
        tx_req = 1; tick();
        chk("R13 hold before end", scl_hold, 1);
        tx_req = 0; xfer_end = 1; tick(); xfer_end = 0;
        chk("R13 hold released", scl_hold, 0);
        chk("R13 no tx_done", tx_done, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule